// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol-to-Nibble Chain

This block sits behind the analog front end of a 100 Mb/s twisted-pair receiver. It receives one sliced three-level line symbol per bit clock and recovers the MII receive stream from it. The stages run in a fixed order. A level-change detector undoes the MLT-3 line coding. A transition detector then undoes the NRZI coding. An 11-bit additive de-scrambler follows. The last stage aligns the bit stream to 5-bit code groups, translates them to nibbles and frames the packet.

The de-scrambler begins in a search state. In that state it loads its shift register from the received stream on the assumption that the line carries idle, which is all ones before scrambling. It declares lock once enough consecutive recovered ones confirm that guess. Until then nothing downstream moves. After lock, the aligner looks for the start-of-stream pair and fixes the code-group boundary from its position. It then emits one nibble per five bit cycles, together with a strobe, until the end-of-stream pair arrives.

Top module: `pcs_rx_chain`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `rx_locked`, `rx_stb`, `rx_dv`, `rx_er` and `rx_d` are all zero.
- R2: `line_sym` codes the line level as 2'b01 = +1, 2'b00 = 0 and 2'b11 = -1. A cycle whose level differs from the previous cycle's level yields a 1 and an unchanged level yields a 0. That bit is then turned to NRZ as the XOR of itself and the previous such bit.
- R3: Plain bit = received bit XOR key, where key k[n] = k[n-11] XOR k[n-9] (polynomial x^11 + x^9 + 1).
- R4: `rx_locked` rises after 30 consecutive de-scrambled ones and then stays high until reset. A line held at one constant level never locks. While unlocked, `rx_stb`, `rx_dv` and `rx_er` stay low.
- R5: When locked and not inside a frame, the 10-bit sequence 11000 10001 (leftmost bit received first) starts a frame. The next five bits form the first code group.
- R6: Data code groups map to nibbles 0..F as 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101, with the leftmost bit received first.
- R7: Once locked, `rx_stb` pulses for one cycle every five cycles. Successive pulses are never fewer than five cycles apart. `rx_dv`, `rx_er` and `rx_d` change only in a cycle where `rx_stb` is high.
- R8: Nibbles leave in the order their code groups arrived. A byte sent low group first therefore appears on `rx_d` low nibble first.
- R9: `rx_dv` is high on every strobe that carries a data group after the start pair. It goes low on the strobe of a 01101 group. A following 00111 group ends the frame with `rx_er` low.
- R10: Inside a frame, a code group that is neither data nor 01101 gives `rx_dv` = 1, `rx_er` = 1 and `rx_d` = 0 for that strobe, and the frame continues.
- R11: If the group after 01101 is not 00111, that strobe shows `rx_er` = 1 with `rx_dv` = 0. The block then returns to searching for a start pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one line symbol per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_sym | input | 2 | Sliced line level: 01 = +1, 00 = 0, 11 = -1 |
| rx_locked | output | 1 | De-scrambler synchronized to the idle stream |
| rx_stb | output | 1 | One-cycle nibble strobe, once per code group |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error |
| rx_d | output | 4 | Receive nibble |

## Verification
The hardest state to reach from the ports is a start pair that lands at every possible offset against the free-running group phase. Reaching it needs a locked de-scrambler first, and lock depends on an arbitrary transmitter seed. The bench models a complete transmitter (scrambler, NRZI and MLT-3 coders), seeds it differently for each run, and varies the idle length before the start pair so that the pair meets all five phases. It sweeps all 256 byte values through the decoder, then forces a bad code group and a broken end pair inside otherwise normal frames.

// File: rtl/pcs_rx_pkg.sv
package pcs_rx_pkg;

    localparam int CG_W     = 5;
    localparam int NIB_W    = 4;
    localparam int LFSR_W   = 11;
    localparam int LFSR_TAP = 9;

    typedef logic [1:0]       lvl_t;
    typedef logic [CG_W-1:0]  cg_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam cg_t CG_SSD1 = 5'b11000;
    localparam cg_t CG_SSD2 = 5'b10001;
    localparam cg_t CG_ESD1 = 5'b01101;
    localparam cg_t CG_ESD2 = 5'b00111;

    typedef struct packed {
        logic ok;
        nib_t nib;
    } cg_dec_t;

    typedef enum logic [1:0] {
        FR_HUNT = 2'd0,
        FR_DATA = 2'd1,
        FR_TAIL = 2'd2
    } fr_state_e;

    typedef struct packed {
        logic stb;
        logic dv;
        logic er;
        nib_t d;
    } mii_out_t;

    function automatic cg_dec_t cg_decode(input cg_t g);
        cg_dec_t r;
        r.ok  = 1'b1;
        r.nib = '0;
        case (g)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default:  r.ok  = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcs_rx_line_dec.sv
module pcs_rx_line_dec
    import pcs_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  lvl_t sym_i,
    output logic nrz_o
);
    lvl_t prev_lvl;
    logic chg_q;
    logic chg_prev;

    // Stage 1: level change marks a one; stage 2: transition marks a one.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= '0;
            chg_q    <= 1'b0;
            chg_prev <= 1'b0;
            nrz_o    <= 1'b0;
        end else begin
            prev_lvl <= sym_i;
            chg_q    <= (sym_i != prev_lvl);
            chg_prev <= chg_q;
            nrz_o    <= chg_q ^ chg_prev;
        end
    end

endmodule

// File: rtl/pcs_rx_descram.sv
module pcs_rx_descram
    import pcs_rx_pkg::*;
#(
    parameter int LOCK_RUN = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic s_i,
    output logic d_o,
    output logic vld_o,
    output logic locked_o
);
    localparam int CNT_W = $clog2(LOCK_RUN + 1);

    logic [LFSR_W-1:0] st;
    logic [CNT_W-1:0]  run;
    logic              key;
    logic              plain;

    always_comb begin
        key   = st[LFSR_W-1] ^ st[LFSR_TAP-1];
        plain = s_i ^ key;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= '0;
            run      <= '0;
            locked_o <= 1'b0;
            d_o      <= 1'b0;
            vld_o    <= 1'b0;
        end else begin
            // Unlocked: assume idle (plain one), so the key equals the inverted line bit.
            st    <= {st[LFSR_W-2:0], (locked_o ? key : ~s_i)};
            d_o   <= plain;
            vld_o <= locked_o;
            if (!locked_o) begin
                if (plain) begin
                    run <= run + 1'b1;
                    if (run == CNT_W'(LOCK_RUN - 1))
                        locked_o <= 1'b1;
                end else begin
                    run <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/pcs_rx_align_dec.sv
module pcs_rx_align_dec
    import pcs_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_i,
    input  logic     vld_i,
    output mii_out_t q_o
);
    localparam int          HIST_W  = 2 * CG_W - 1;
    localparam logic [2:0]  PH_LAST = 3'(CG_W - 1);

    logic [HIST_W-1:0] hist;
    logic [2:0]        ph;
    fr_state_e         state;
    cg_t               grp;
    cg_dec_t           dec;
    logic              sop_hit;
    logic              grp_done;

    always_comb begin
        grp      = {hist[CG_W-2:0], bit_i};
        dec      = cg_decode(grp);
        sop_hit  = vld_i && (state == FR_HUNT) && ({hist, bit_i} == {CG_SSD1, CG_SSD2});
        grp_done = vld_i && (ph == PH_LAST) && !sop_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            ph    <= '0;
            state <= FR_HUNT;
            q_o   <= '0;
        end else begin
            q_o.stb <= grp_done;
            if (vld_i)
                hist <= {hist[HIST_W-2:0], bit_i};

            if (sop_hit) begin
                ph    <= '0;
                state <= FR_DATA;
            end else if (vld_i) begin
                ph <= (ph == PH_LAST) ? 3'd0 : ph + 3'd1;
            end

            if (grp_done) begin
                case (state)
                    FR_DATA: begin
                        if (dec.ok) begin
                            q_o.dv <= 1'b1;
                            q_o.er <= 1'b0;
                            q_o.d  <= dec.nib;
                        end else if (grp == CG_ESD1) begin
                            q_o.dv <= 1'b0;
                            q_o.er <= 1'b0;
                            q_o.d  <= '0;
                            state  <= FR_TAIL;
                        end else begin
                            q_o.dv <= 1'b1;
                            q_o.er <= 1'b1;
                            q_o.d  <= '0;
                        end
                    end
                    FR_TAIL: begin
                        q_o.dv <= 1'b0;
                        q_o.er <= (grp != CG_ESD2);
                        q_o.d  <= '0;
                        state  <= FR_HUNT;
                    end
                    default: begin
                        q_o.dv <= 1'b0;
                        q_o.er <= 1'b0;
                        q_o.d  <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pcs_rx_chain.sv
module pcs_rx_chain
    import pcs_rx_pkg::*;
#(
    parameter int LOCK_RUN = 30
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] line_sym,
    output logic       rx_locked,
    output logic       rx_stb,
    output logic       rx_dv,
    output logic       rx_er,
    output logic [3:0] rx_d
);
    logic     nrz_bit;
    logic     ds_bit;
    logic     ds_vld;
    mii_out_t mii;

    pcs_rx_line_dec i_line (
        .clk   (clk),
        .rst   (rst),
        .sym_i (line_sym),
        .nrz_o (nrz_bit)
    );

    pcs_rx_descram #(.LOCK_RUN(LOCK_RUN)) i_descram (
        .clk      (clk),
        .rst      (rst),
        .s_i      (nrz_bit),
        .d_o      (ds_bit),
        .vld_o    (ds_vld),
        .locked_o (rx_locked)
    );

    pcs_rx_align_dec i_align (
        .clk   (clk),
        .rst   (rst),
        .bit_i (ds_bit),
        .vld_i (ds_vld),
        .q_o   (mii)
    );

    assign rx_stb = mii.stb;
    assign rx_dv  = mii.dv;
    assign rx_er  = mii.er;
    assign rx_d   = mii.d;

endmodule

// File: rtl/pcs_rx_chain_chk.sv
module pcs_rx_chain_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_locked,
    input logic       rx_stb,
    input logic       rx_dv,
    input logic       rx_er,
    input logic [3:0] rx_d
);
    p_hold_between_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_stb |-> $stable({rx_dv, rx_er, rx_d}));

    p_stb_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        rx_stb |-> (!$past(rx_stb, 1) && !$past(rx_stb, 2) &&
                    !$past(rx_stb, 3) && !$past(rx_stb, 4)));

    p_quiet_unlocked_r4: assert property (@(posedge clk) disable iff (rst)
        !rx_locked |-> (!rx_stb && !rx_dv && !rx_er));

    p_lock_kept_r4: assert property (@(posedge clk) disable iff (rst)
        rx_locked |=> rx_locked);

    p_dv_fall_on_stb_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dv) |-> rx_stb);

    p_err_nibble_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_stb && rx_er && rx_dv) |-> (rx_d == 4'h0));

endmodule

bind pcs_rx_chain pcs_rx_chain_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_locked (rx_locked),
    .rx_stb    (rx_stb),
    .rx_dv     (rx_dv),
    .rx_er     (rx_er),
    .rx_d      (rx_d)
);

// File: tb/test_pcs_rx_chain.sv
module test_pcs_rx_chain;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] line_sym = 2'b00;
    logic       rx_locked, rx_stb, rx_dv, rx_er;
    logic [3:0] rx_d;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // Transmitter model
    logic [10:0] tx_st;
    logic        tx_t;
    int          tx_phase;

    // Monitor storage
    logic [3:0] got[600];
    int         got_n = 0;
    int         er_n  = 0;
    int         stb_n = 0;
    logic [3:0] expn[600];
    int         exp_n = 0;

    always #10 clk = ~clk;

    pcs_rx_chain i_pcs_rx_chain (
        .clk       (clk),
        .rst       (rst),
        .line_sym  (line_sym),
        .rx_locked (rx_locked),
        .rx_stb    (rx_stb),
        .rx_dv     (rx_dv),
        .rx_er     (rx_er),
        .rx_d      (rx_d)
    );

    always @(negedge clk) begin
        if (!rst && rx_stb) begin
            stb_n = stb_n + 1;
            if (rx_dv) begin
                if (got_n < 600) got[got_n] = rx_d;
                got_n = got_n + 1;
            end
            if (rx_er) er_n = er_n + 1;
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            n_tests = n_tests + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            summary();
        end
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int expv);
        n_tests = n_tests + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: enc = 5'b11110; 4'h1: enc = 5'b01001;
            4'h2: enc = 5'b10100; 4'h3: enc = 5'b10101;
            4'h4: enc = 5'b01010; 4'h5: enc = 5'b01011;
            4'h6: enc = 5'b01110; 4'h7: enc = 5'b01111;
            4'h8: enc = 5'b10010; 4'h9: enc = 5'b10011;
            4'hA: enc = 5'b10110; 4'hB: enc = 5'b10111;
            4'hC: enc = 5'b11010; 4'hD: enc = 5'b11011;
            4'hE: enc = 5'b11100; default: enc = 5'b11101;
        endcase
    endfunction

    // Scramble (R3), NRZI and MLT-3 code (R2) one plain bit.
    task automatic send_bit(input logic p);
        logic key;
        key   = tx_st[10] ^ tx_st[8];
        tx_st = {tx_st[9:0], key};
        tx_t  = tx_t ^ (p ^ key);
        if (tx_t) tx_phase = (tx_phase + 1) % 4;
        @(negedge clk);
        case (tx_phase)
            1:       line_sym = 2'b01;
            3:       line_sym = 2'b11;
            default: line_sym = 2'b00;
        endcase
    endtask

    task automatic send_grp(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic do_reset(input logic [10:0] seed);
        @(negedge clk);
        rst      = 1'b1;
        line_sym = 2'b00;
        tx_st    = seed;
        tx_t     = 1'b0;
        tx_phase = 0;
        repeat (5) @(negedge clk);
        got_n = 0; er_n = 0; stb_n = 0; exp_n = 0;
        rst = 1'b0;
    endtask

    task automatic add_exp(input logic [3:0] n);
        expn[exp_n] = n;
        exp_n = exp_n + 1;
    endtask

    task automatic cmp_stream(input string tag);
        int mism;
        mism = 0;
        for (int i = 0; i < exp_n; i++)
            if (i < got_n && got[i] !== expn[i]) mism++;
        chk(got_n == exp_n, tag, "nibble count", got_n, exp_n);
        chk(mism == 0, tag, "nibble mismatches", mism, 0);
    endtask

    task automatic lock_up(input int idle_len);
        int s0;
        send_idle(idle_len);
        #1;
        chk(rx_locked === 1'b1, "R4", "lock after idle", int'(rx_locked), 1);
        s0 = stb_n;
        send_idle(50);
        #1;
        chk(stb_n - s0 == 10, "R7", "strobes in 50 cycles", stb_n - s0, 10);
        chk(got_n == 0, "R9", "valid nibbles before start pair", got_n, 0);
    endtask

    task automatic frame_test(input logic [10:0] seed, input int idle_len,
                              input int nbytes, input int mul, input int add);
        logic [7:0] b;
        do_reset(seed);
        lock_up(idle_len);
        send_grp(5'b11000);
        send_grp(5'b10001);
        for (int i = 0; i < nbytes; i++) begin
            b = 8'((i * mul + add) & 255);
            send_grp(enc(b[3:0]));
            send_grp(enc(b[7:4]));
            add_exp(b[3:0]);
            add_exp(b[7:4]);
        end
        send_grp(5'b01101);
        send_grp(5'b00111);
        send_idle(25);
        #1;
        cmp_stream("R2 R3 R5 R6 R8 R9");
        chk(er_n == 0, "R10", "error strobes in clean frame", er_n, 0);
    endtask

    initial begin
        // R1: reset state
        do_reset(11'h001);
        #1;
        chk({rx_locked, rx_stb, rx_dv, rx_er, rx_d} == 8'h00, "R1",
            "outputs after reset", int'({rx_locked, rx_stb, rx_dv, rx_er, rx_d}), 0);

        // R4: constant line never locks
        repeat (150) @(negedge clk);
        #1;
        chk(rx_locked === 1'b0, "R4", "lock on constant line", int'(rx_locked), 0);
        chk(stb_n == 0, "R4", "strobes while unlocked", stb_n, 0);

        // Frame sweep: varied seeds and idle lengths move the start pair phase
        frame_test(11'h001, 80, 256, 1, 0);
        frame_test(11'h7FF, 83, 1, 1, 165);
        frame_test(11'h2A5, 91, 7, 37, 11);
        frame_test(11'h4C3, 97, 33, 91, 200);
        frame_test(11'h155, 84, 5, 13, 60);

        // R10: invalid code group inside a frame
        do_reset(11'h3C1);
        lock_up(82);
        send_grp(5'b11000); send_grp(5'b10001);
        send_grp(enc(4'h3)); send_grp(enc(4'h9));
        send_grp(5'b00000);
        send_grp(enc(4'h6));
        send_grp(5'b01101); send_grp(5'b00111);
        send_idle(25);
        #1;
        add_exp(4'h3); add_exp(4'h9); add_exp(4'h0); add_exp(4'h6);
        cmp_stream("R10");
        chk(er_n == 1, "R10", "error strobes", er_n, 1);

        // R11: end pair broken by idle, then a new frame is accepted
        do_reset(11'h0F3);
        lock_up(86);
        send_grp(5'b11000); send_grp(5'b10001);
        send_grp(enc(4'hA)); send_grp(enc(4'h5));
        send_grp(5'b01101); send_grp(5'b11111);
        send_idle(25);
        #1;
        add_exp(4'hA); add_exp(4'h5);
        cmp_stream("R11");
        chk(er_n == 1, "R11", "error strobes after bad tail", er_n, 1);
        send_grp(5'b11000); send_grp(5'b10001);
        send_grp(enc(4'h1)); send_grp(enc(4'h2));
        send_grp(5'b01101); send_grp(5'b00111);
        send_idle(25);
        #1;
        add_exp(4'h1); add_exp(4'h2);
        cmp_stream("R11 R5");
        chk(er_n == 1, "R11", "no further errors after restart", er_n, 1);

        summary();
    end

endmodule